// File: doc/BRIEF.md
# Paired PWM Group

The block generates four pulse-width-modulated lines, organised as two pairs, from one shared time base. The time base either counts upward and wraps, which gives edge-aligned pulses that start together at the beginning of each period, or counts up to the period value and back down, which gives pulses centred on the turn-around point. A surrounding register block drives the period, the four duty values and the mode bits as steady levels. The generator copies them into its own working registers only at defined instants, so a change made part-way through a period never produces a partial or glitched pulse.

Each pair runs in one of two modes. In complementary mode the second line is the inverse of the first. In independent mode each line follows its own duty value. In centre-aligned operation the duty values are normally taken once per period, which makes every pulse symmetric. With double update turned on, they are also taken at the turn-around point, so the second half of a pulse can differ from the first. A one-cycle strobe marks the start of every period, so software or a DMA engine can pace its updates.

Top module: `pwm_pair_group`

## Requirements
- R1: Edge-aligned mode (`centerMode`=0): with an active period P, the counter steps 0,1,...,P-1 and then returns to 0, so a period lasts P cycles. Output k is high while the count is below its duty value, which gives D high cycles per period.
- R2: Centre-aligned mode (`centerMode`=1): the counter steps 0,1,...,P, then P-1,...,1, and then returns to 0, so a period lasts 2P cycles. For 1 <= D < P, output k is high while count + D > P. This gives 2D-1 high cycles, placed symmetrically about the turn-around cycle, which sits at offset P from the period start.
- R3: The period, the duty values, the mode bits and the pairing bits are copied from the inputs only at a period start, that is, on the edge at which the count returns to 0. Input changes made at any other time have no effect until the next period.
- R4: When double update was set at the last period start and the block is in centre-aligned mode, the four duty values (and nothing else) are also copied on the edge at which the count reaches P. The high cycles after the turn-around therefore follow the new duty value.
- R5: When `pairMode[p]`=1, output 2p+1 is the inverse of output 2p on every cycle while the block runs, and duty value 2p+1 is not used.
- R6: When `pairMode[p]`=0, outputs 2p and 2p+1 each follow their own duty value. Duty value k occupies bits [16k+15:16k] of `dutyIn`.
- R7: A duty value of 0 holds the output low for the whole period. A duty value equal to or above P holds it high for the whole period, in both alignment modes.
- R8: While `enable` is low, from the first edge after it falls, all four outputs and the strobe are low and the count is 0, and the working registers follow the inputs on every edge. On the first cycle after `enable` returns high, the count is 0 and the strobe is high.
- R9: `periodStrobe` is high for exactly one cycle at the start of every period, in the cycle in which the count is 0 while the block runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the time base; low forces the outputs low |
| centerMode | input | 1 | 1 = centre-aligned, 0 = edge-aligned |
| doubleUpdate | input | 1 | Also reload the duty values at the turn-around in centre-aligned mode |
| pairMode | input | 2 | Per pair: 1 = complementary, 0 = independent |
| periodIn | input | 16 | Period value P |
| dutyIn | input | 64 | Four 16-bit duty values, channel k in bits [16k+15:16k] |
| pwmOut | output | 4 | PWM lines, channel k on bit k |
| periodStrobe | output | 1 | One-cycle pulse at each period start |

## Verification
The embedded properties assume that `periodIn` is at least 2 whenever the block runs, so a period never shrinks to a single cycle and the strobe can never be high on two cycles in a row. The stimulus only ever uses periods of 8 and 10. It changes every input on the falling clock edge, including mid-period duty changes made on purpose to exercise the reload instants, so each value stays stable across the rising edge that samples it.

// File: rtl/pwm_group_pkg.sv
package pwm_group_pkg;

  // Strobes and state the time base hands to the compare datapath.
  typedef struct packed {
    logic running;   // time base active
    logic center;    // active alignment mode
    logic loadAll;   // this edge starts a new period
    logic loadMid;   // this edge reaches the turn-around with double update
  } tbStrobe_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_group_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             centerMode,
  input  logic             doubleUpdate,
  input  logic [CNT_W-1:0] periodIn,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] actPeriod,
  output tbStrobe_t        strobe,
  output logic             periodStart
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cntQ, cntD, perQ;
  logic             downQ, downD, runQ, cenQ, dblQ;
  logic             loadAll, loadMid;
  logic [EXT_W-1:0] cntInc;

  assign cntInc = {1'b0, cntQ} + EXT_W'(1);

  always_comb begin
    cntD    = cntQ;
    downD   = downQ;
    loadAll = 1'b0;
    loadMid = 1'b0;
    if (!enable) begin
      cntD    = '0;
      downD   = 1'b0;
      loadAll = 1'b1;
    end else if (!runQ) begin
      cntD  = '0;
      downD = 1'b0;
    end else if (cenQ) begin
      if (!downQ) begin
        cntD = cntInc[CNT_W-1:0];
        if (cntInc >= {1'b0, perQ}) begin
          downD   = 1'b1;
          loadMid = dblQ;
        end
      end else if (cntQ <= CNT_W'(1)) begin
        cntD    = '0;
        downD   = 1'b0;
        loadAll = 1'b1;
      end else begin
        cntD = cntQ - CNT_W'(1);
      end
    end else begin
      if (cntInc >= {1'b0, perQ}) begin
        cntD    = '0;
        loadAll = 1'b1;
      end else begin
        cntD = cntInc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ  <= '0;
      downQ <= 1'b0;
      runQ  <= 1'b0;
      perQ  <= '0;
      cenQ  <= 1'b0;
      dblQ  <= 1'b0;
    end else begin
      cntQ  <= cntD;
      downQ <= downD;
      runQ  <= enable;
      if (loadAll) begin
        perQ <= periodIn;
        cenQ <= centerMode;
        dblQ <= doubleUpdate;
      end
    end
  end

  assign cnt            = cntQ;
  assign actPeriod      = perQ;
  assign periodStart    = runQ && (cntQ == '0);
  assign strobe.running = runQ;
  assign strobe.center  = cenQ;
  assign strobe.loadAll = loadAll;
  assign strobe.loadMid = loadMid;

  // R8: a low enable clears the count and silences the strobe on the next cycle
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0 && !periodStart));

  // R3: the active period only changes on a period-start edge
  a_r3_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (perQ != $past(perQ)) |-> $past(loadAll));

  // R2: the centre-aligned count never passes the active period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && cenQ) |-> (cntQ <= perQ));

  // R1: the edge-aligned count stays below a nonzero active period
  a_r1_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !cenQ && perQ != '0) |-> (cntQ < perQ));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_group_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_PAIRS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  tbStrobe_t                    strobe,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [CNT_W-1:0]             actPeriod,
  input  logic [2*NUM_PAIRS*CNT_W-1:0] dutyIn,
  input  logic [NUM_PAIRS-1:0]         pairMode,
  output logic [2*NUM_PAIRS-1:0]       pwm
);

  localparam int NUM_CH = 2 * NUM_PAIRS;
  localparam int EXT_W  = CNT_W + 1;

  logic [NUM_CH-1:0][CNT_W-1:0] actDuty;
  logic [NUM_PAIRS-1:0]         actPair;
  logic [NUM_CH-1:0]            raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actDuty <= '0;
      actPair <= '0;
    end else begin
      if (strobe.loadAll || strobe.loadMid) begin
        actDuty <= dutyIn;
      end
      if (strobe.loadAll) begin
        actPair <= pairMode;
      end
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    logic [EXT_W-1:0] sumK;
    logic             fullK;
    assign sumK  = {1'b0, cnt} + {1'b0, actDuty[k]};
    assign fullK = (actDuty[k] >= actPeriod);
    assign raw[k] = strobe.running &&
                    (strobe.center ? (fullK || (sumK > {1'b0, actPeriod}))
                                   : (cnt < actDuty[k]));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pwm[2*p]   = raw[2*p];
    assign pwm[2*p+1] = actPair[p] ? (strobe.running && !raw[2*p]) : raw[2*p+1];

    // R5: a complementary pair always shows opposite levels while running
    a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.running && actPair[p]) |-> (pwm[2*p+1] != pwm[2*p]));
  end

  // R4: the working duty values change only on a period start or turn-around edge
  a_r4_duty_load: assert property (@(posedge clk) disable iff (!rst_n)
    (actDuty != $past(actDuty)) |-> $past(strobe.loadAll || strobe.loadMid));

  // R8: no output is high while the time base is stopped
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.running |-> (pwm == '0));

endmodule

// File: rtl/pwm_pair_group.sv
module pwm_pair_group
  import pwm_group_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_PAIRS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         centerMode,
  input  logic                         doubleUpdate,
  input  logic [NUM_PAIRS-1:0]         pairMode,
  input  logic [CNT_W-1:0]             periodIn,
  input  logic [2*NUM_PAIRS*CNT_W-1:0] dutyIn,
  output logic [2*NUM_PAIRS-1:0]       pwmOut,
  output logic                         periodStrobe
);

  tbStrobe_t        tbStrobe;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] activePeriod;

  pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .centerMode   (centerMode),
    .doubleUpdate (doubleUpdate),
    .periodIn     (periodIn),
    .cnt          (count),
    .actPeriod    (activePeriod),
    .strobe       (tbStrobe),
    .periodStart  (periodStrobe)
  );

  pwm_compare #(.CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS)) u_compare (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (tbStrobe),
    .cnt       (count),
    .actPeriod (activePeriod),
    .dutyIn    (dutyIn),
    .pairMode  (pairMode),
    .pwm       (pwmOut)
  );

  // R9: the period strobe never lasts two cycles (period of at least 2 assumed)
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    periodStrobe |=> !periodStrobe);

endmodule

// File: tb/tb_pwm_pair_group.sv
module tb_pwm_pair_group;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        centerMode = 1'b0;
  logic        doubleUpdate = 1'b0;
  logic [1:0]  pairMode = 2'b00;
  logic [15:0] periodIn = 16'd8;
  logic [63:0] dutyIn = '0;
  logic [3:0]  pwmOut;
  logic        periodStrobe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pwm_pair_group dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .centerMode(centerMode),
    .doubleUpdate(doubleUpdate), .pairMode(pairMode), .periodIn(periodIn),
    .dutyIn(dutyIn), .pwmOut(pwmOut), .periodStrobe(periodStrobe)
  );

  // behavioural reference
  int mCnt, mP;
  bit mDown, mRun, mCen, mDbl;
  int mD [4];
  bit mPair [2];

  task automatic mLoadDuty();
    for (int k = 0; k < 4; k++) mD[k] = int'(dutyIn[16*k +: 16]);
  endtask

  task automatic mLoadAll();
    mLoadDuty();
    mP   = int'(periodIn);
    mCen = centerMode;
    mDbl = doubleUpdate;
    mPair[0] = pairMode[0];
    mPair[1] = pairMode[1];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt = 0; mDown = 0; mRun = 0; mP = 0; mCen = 0; mDbl = 0;
      for (int k = 0; k < 4; k++) mD[k] = 0;
      mPair[0] = 0; mPair[1] = 0;
    end else if (!enable) begin
      mRun = 0; mCnt = 0; mDown = 0; mLoadAll();
    end else if (!mRun) begin
      mRun = 1;
    end else if (mCen) begin
      if (!mDown) begin
        mCnt++;
        if (mCnt >= mP) begin mDown = 1; if (mDbl) mLoadDuty(); end
      end else begin
        mCnt--;
        if (mCnt <= 0) begin mCnt = 0; mDown = 0; mLoadAll(); end
      end
    end else begin
      mCnt++;
      if (mCnt >= mP) begin mCnt = 0; mLoadAll(); end
    end
  end

  function automatic bit mRaw(int k);
    if (!mRun) return 0;
    if (mCen) return (mD[k] >= mP) || (mCnt + mD[k] > mP);
    return mCnt < mD[k];
  endfunction

  function automatic logic [3:0] mOut();
    logic [3:0] o;
    for (int p = 0; p < 2; p++) begin
      o[2*p]   = mRaw(2*p);
      o[2*p+1] = mPair[p] ? (mRun && !mRaw(2*p)) : mRaw(2*p+1);
    end
    return o;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check(mCen ? "R2 cycle compare pwm" : "R1 cycle compare pwm",
            int'(pwmOut), int'(mOut()));
      check("R9 cycle compare strobe", int'(periodStrobe),
            int'(mRun && mCnt == 0));
    end
  end

  task automatic setDuty(int ch, int val);
    dutyIn[16*ch +: 16] = 16'(val);
  endtask

  task automatic waitStrobe();
    forever begin
      @(negedge clk);
      if (periodStrobe) break;
    end
  endtask

  int hi [4];
  int firstHi [4];
  int lastHi [4];
  int strobes;

  // Starting on a strobe cycle, measure len cycles; optionally change one duty at offset chgAt.
  task automatic measure(int len, int chgAt, int chgCh, int chgVal);
    strobes = 0;
    for (int k = 0; k < 4; k++) begin hi[k] = 0; firstHi[k] = -1; lastHi[k] = -1; end
    for (int o = 0; o < len; o++) begin
      if (periodStrobe) strobes++;
      for (int k = 0; k < 4; k++) begin
        if (pwmOut[k]) begin
          hi[k]++;
          if (firstHi[k] < 0) firstHi[k] = o;
          lastHi[k] = o;
        end
      end
      if (o == chgAt) setDuty(chgCh, chgVal);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset pwm low", int'(pwmOut), 0);
    check("R8 reset strobe low", int'(periodStrobe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 disabled pwm low", int'(pwmOut), 0);

    // edge-aligned, independent
    periodIn = 16'd8; centerMode = 0; pairMode = 2'b00;
    setDuty(0, 3); setDuty(1, 0); setDuty(2, 12); setDuty(3, 5);
    @(negedge clk);
    enable = 1'b1;
    waitStrobe();
    measure(8, -1, 0, 0);
    check("R1 edge duty 3", hi[0], 3);
    check("R1 edge first high at start", firstHi[0], 0);
    check("R7 edge duty 0 low", hi[1], 0);
    check("R7 edge duty above period high", hi[2], 8);
    check("R6 edge independent duty 5", hi[3], 5);
    check("R9 one strobe per edge period", strobes, 1);

    // centre-aligned, independent
    centerMode = 1;
    setDuty(1, 0); setDuty(2, 12); setDuty(3, 8);
    waitStrobe();
    measure(16, -1, 0, 0);
    check("R2 centre duty 3 width", hi[0], 5);
    check("R2 centre first high", firstHi[0], 6);
    check("R2 centre symmetric", firstHi[0] + lastHi[0], 16);
    check("R7 centre duty 0 low", hi[1], 0);
    check("R7 centre duty above period high", hi[2], 16);
    check("R7 centre duty equal period high", hi[3], 16);
    check("R9 one strobe per centre period", strobes, 1);

    // pair 0 complementary, pair 1 independent
    pairMode = 2'b01; setDuty(1, 7); setDuty(2, 2); setDuty(3, 4);
    waitStrobe();
    measure(16, -1, 0, 0);
    check("R5 complement of duty 3", hi[1], 11);
    check("R6 independent duty 2", hi[2], 3);
    check("R6 independent duty 4", hi[3], 7);

    // both pairs complementary
    pairMode = 2'b11;
    waitStrobe();
    measure(16, -1, 0, 0);
    check("R5 second pair complement", hi[3], 13);

    // single update: mid-period change waits for next period
    pairMode = 2'b00; doubleUpdate = 0; setDuty(0, 2);
    waitStrobe();
    measure(16, 2, 0, 5);
    check("R3 mid-period change ignored", hi[0], 3);
    measure(16, -1, 0, 0);
    check("R3 change applied next period", hi[0], 9);

    // double update: change takes effect after the turn-around
    doubleUpdate = 1; setDuty(0, 2);
    waitStrobe();
    measure(16, 2, 0, 5);
    check("R4 asymmetric pulse width", hi[0], 6);
    check("R4 first half uses old duty", firstHi[0], 7);
    check("R4 second half uses new duty", lastHi[0], 12);
    measure(16, -1, 0, 0);
    check("R4 following period symmetric", hi[0], 9);

    // disable mid-period, then restart
    repeat (3) @(negedge clk);
    enable = 0;
    @(negedge clk);
    check("R8 disable pwm low", int'(pwmOut), 0);
    check("R8 disable strobe low", int'(periodStrobe), 0);
    repeat (4) @(negedge clk);
    check("R8 stays low while disabled", int'(pwmOut), 0);
    enable = 1;
    @(negedge clk);
    check("R8 restart begins at count 0", int'(periodStrobe), 1);

    // edge-aligned period change mid-period
    centerMode = 0; doubleUpdate = 0; setDuty(0, 3);
    waitStrobe();
    periodIn = 16'd10;
    measure(8, -1, 0, 0);
    check("R3 period change waits for boundary", int'(periodStrobe), 1);
    measure(10, -1, 0, 0);
    check("R3 new period length", int'(periodStrobe), 1);
    check("R1 duty 3 at period 10", hi[0], 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule